// File: doc/BRIEF.md
# Backlight PWM Generator with Register Control

This block drives a panel backlight from a byte-wide register port. A host writes the control mode, an enable bit, a brightness level, a PWM bit count (Pn) and an 8-bit frequency pre-divider (F). The block turns a reference tick enable into a PWM waveform. Its period is the active divider times 2^Pn reference ticks. Its high time is the active level times the divider, in reference ticks.

Every register can be read back. The level actually driving the output is also brought out on its own port. That level is the programmed one in register-controlled mode and full scale (2^Pn − 1) in the other three modes. New values for divider, bit count and level are taken over only when a PWM period ends, so no period is cut short. A build parameter selects the brightness width. In the 16-bit build the high byte is staged and the full level takes effect on the low-byte write. In the 8-bit build the high byte alone is the level.

Top module: `bl_pwm_core`

## Requirements
- R1: With the active divider D and bit count Pn, the output period is D·2^Pn reference ticks and the high time per period is L·D reference ticks, where L is the active level; clock cycles without `ref_tick` do not count.
- R2: Register addresses: 0 = mode (bits 1:0 mode, bit 2 frequency-set enable), 1 = control (bit 0 backlight enable), 2 = level high byte, 3 = level low byte, 4 = bit count (bits 4:0), 5 = pre-divider F (bits 7:0); `rd_data` returns the addressed register in the same cycle, and bits 7:5 of a bit-count write are dropped (read back as 0).
- R3: After reset: mode 0, frequency-set enable 0, backlight enable 0, Pn = 8, F = 1, stored level 0, `level_used` 0 and `pwm_out` low.
- R4: The divider is F when the frequency-set enable is 1 (an F of 0 acts as 1), and the parameter DEFAULT_F (4) when it is 0.
- R5: Mode encoding 0 = PWM pin, 1 = preset, 2 = register-controlled, 3 = product-specific; only mode 2 uses the stored level, and the other modes use full scale 2^Pn − 1.
- R6: In mode 2 a stored level above 2^Pn − 1 is used as 2^Pn − 1.
- R7: In the 16-bit build a high-byte write changes neither the level nor its read-back; the following low-byte write sets the level to high·256 + low.
- R8: In the 8-bit build a high-byte write sets the level to that byte, reads of address 2 return it, and address 3 reads 0.
- R9: With the backlight enable at 0 the output stays low; `level_used` is not affected.
- R10: Divider, bit count and level changes reach `level_used` and the output only at the end of a PWM period.
- R11: A bit count above PN_MAX (16) is used as PN_MAX.
- R12: An active level of 0 keeps the output low for the whole period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | One-cycle enable marking each reference tick |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for read and write |
| wr_data | input | 8 | Write data byte |
| rd_data | output | 8 | Read data for `addr` |
| pwm_out | output | 1 | Backlight PWM output |
| level_used | output | 16 | Level currently driving the output |

## Verification
The assertions assume that `ref_tick` is a clean enable synchronous to `clk` and that registers change only through the write port, one write per cycle. Under that assumption the period counter stays at or below full scale, the divider count stays below the active divider, and the active settings move only on a period-end cycle. The stimulus writes one byte per cycle and waits long enough for the settings to settle, bounded by the larger of the old and new period. It then measures the output over a window of two whole periods. Because the waveform is periodic, high-cycle and rising-edge counts in such a window do not depend on phase.

// File: rtl/bl_pwm_pkg.sv
package bl_pwm_pkg;

  localparam int LVL_W  = 16;
  localparam int ADDR_W = 3;

  typedef enum logic [1:0] {
    MODE_PIN     = 2'd0,
    MODE_PRESET  = 2'd1,
    MODE_REG     = 2'd2,
    MODE_PRODUCT = 2'd3
  } bl_mode_e;

  localparam logic [ADDR_W-1:0] A_MODE   = 3'd0;
  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd1;
  localparam logic [ADDR_W-1:0] A_LVL_HI = 3'd2;
  localparam logic [ADDR_W-1:0] A_LVL_LO = 3'd3;
  localparam logic [ADDR_W-1:0] A_PNBITS = 3'd4;
  localparam logic [ADDR_W-1:0] A_FDIV   = 3'd5;

  // Largest count value for a given bit count: 2^pn - 1
  function automatic logic [31:0] full_scale(input logic [4:0] pn);
    return (32'd1 << pn) - 32'd1;
  endfunction

  // Bit counts above the build limit are pinned to the limit
  function automatic logic [4:0] clamp_pn(input logic [4:0] pn, input int lim);
    if (int'(pn) > lim) return 5'(lim);
    return pn;
  endfunction

  // Divider choice: programmed value only when enabled, zero acts as one
  function automatic logic [7:0] pick_div(input logic fen, input logic [7:0] f,
                                          input logic [7:0] dflt);
    if (!fen) return dflt;
    if (f == 8'd0) return 8'd1;
    return f;
  endfunction

  // Level choice: stored level in register mode (bounded), full scale otherwise
  function automatic logic [LVL_W-1:0] sel_level(input bl_mode_e mode,
                                                 input logic [LVL_W-1:0] raw,
                                                 input logic [LVL_W-1:0] fs);
    if (mode != MODE_REG) return fs;
    if (raw > fs) return fs;
    return raw;
  endfunction

endpackage

// File: rtl/bl_regs.sv
module bl_regs
  import bl_pwm_pkg::*;
#(
  parameter bit LEVEL16  = 1'b1,
  parameter int RESET_PN = 8,
  parameter int RESET_F  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data,
  output bl_mode_e          mode,
  output logic              fen,
  output logic              en,
  output logic [4:0]        pn_raw,
  output logic [7:0]        f_raw,
  output logic [LVL_W-1:0]  level_raw
);

  bl_mode_e         mode_q;
  logic             fen_q;
  logic             en_q;
  logic [4:0]       pn_q;
  logic [7:0]       f_q;
  logic [7:0]       hold_q;
  logic [LVL_W-1:0] level_q;

  // named write events for the checks below
  logic msb_wr;
  logic lsb_wr;
  assign msb_wr = wr_en && (addr == A_LVL_HI);
  assign lsb_wr = wr_en && (addr == A_LVL_LO);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= MODE_PIN;
      fen_q   <= 1'b0;
      en_q    <= 1'b0;
      pn_q    <= 5'(RESET_PN);
      f_q     <= 8'(RESET_F);
      hold_q  <= 8'h00;
      level_q <= '0;
    end else if (wr_en) begin
      case (addr)
        A_MODE: begin
          mode_q <= bl_mode_e'(wr_data[1:0]);
          fen_q  <= wr_data[2];
        end
        A_CTRL:   en_q <= wr_data[0];
        A_LVL_HI: begin
          if (LEVEL16) hold_q <= wr_data;
          else         level_q <= {8'h00, wr_data};
        end
        A_LVL_LO: begin
          if (LEVEL16) level_q <= {hold_q, wr_data};
        end
        A_PNBITS: pn_q <= wr_data[4:0];
        A_FDIV:   f_q  <= wr_data;
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_data = 8'h00;
    case (addr)
      A_MODE:   rd_data = {5'b0, fen_q, mode_q};
      A_CTRL:   rd_data = {7'b0, en_q};
      A_LVL_HI: rd_data = LEVEL16 ? level_q[15:8] : level_q[7:0];
      A_LVL_LO: rd_data = LEVEL16 ? level_q[7:0] : 8'h00;
      A_PNBITS: rd_data = {3'b0, pn_q};
      A_FDIV:   rd_data = f_q;
      default:  rd_data = 8'h00;
    endcase
  end

  assign mode      = mode_q;
  assign fen       = fen_q;
  assign en        = en_q;
  assign pn_raw    = pn_q;
  assign f_raw     = f_q;
  assign level_raw = level_q;

  generate
    if (LEVEL16) begin : g_wide
      AST_MSB_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        msb_wr |=> $stable(level_q)); // R7
      AST_LSB_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        lsb_wr |=> level_q[7:0] == $past(wr_data)); // R7
    end else begin : g_narrow
      AST_BYTE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        msb_wr |=> level_q == {8'h00, $past(wr_data)}); // R8
      AST_LSB_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        lsb_wr |=> $stable(level_q)); // R8
    end
  endgenerate

endmodule

// File: rtl/bl_shadow.sv
module bl_shadow
  import bl_pwm_pkg::*;
#(
  parameter int PN_MAX    = 16,
  parameter int DEFAULT_F = 4,
  parameter int RESET_PN  = 8,
  parameter int RESET_F   = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             period_end,
  input  bl_mode_e         mode,
  input  logic             fen,
  input  logic [4:0]       pn_raw,
  input  logic [7:0]       f_raw,
  input  logic [LVL_W-1:0] level_raw,
  output logic [4:0]       act_pn,
  output logic [7:0]       act_div,
  output logic [LVL_W-1:0] act_lvl
);

  logic [4:0]       next_pn;
  logic [LVL_W-1:0] next_fs;
  logic [LVL_W-1:0] next_lvl;
  logic [7:0]       next_div;
  logic [LVL_W-1:0] act_fs;

  assign next_pn  = clamp_pn(pn_raw, PN_MAX);
  assign next_fs  = LVL_W'(full_scale(next_pn));
  assign next_lvl = sel_level(mode, level_raw, next_fs);
  assign next_div = pick_div(fen, f_raw, 8'(DEFAULT_F));
  assign act_fs   = LVL_W'(full_scale(act_pn));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_pn  <= clamp_pn(5'(RESET_PN), PN_MAX);
      act_div <= pick_div(1'b0, 8'(RESET_F), 8'(DEFAULT_F));
      act_lvl <= '0;
    end else if (period_end) begin
      act_pn  <= next_pn;
      act_div <= next_div;
      act_lvl <= next_lvl;
    end
  end

  AST_HOLD_MIDPERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    !period_end |=> $stable(act_pn) && $stable(act_div) && $stable(act_lvl)); // R10
  AST_LVL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    act_lvl <= act_fs); // R6
  AST_PN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    int'(act_pn) <= PN_MAX); // R11
  AST_DIV_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    act_div != 8'd0); // R4

endmodule

// File: rtl/bl_pwm_gen.sv
module bl_pwm_gen
  import bl_pwm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_tick,
  input  logic             en,
  input  logic [4:0]       act_pn,
  input  logic [7:0]       act_div,
  input  logic [LVL_W-1:0] act_lvl,
  output logic             period_end,
  output logic             pwm_out
);

  logic [7:0]       div_cnt;
  logic [LVL_W-1:0] cnt;
  logic [LVL_W-1:0] fs;
  logic             tick_adv;
  logic             pwm_q;

  assign fs         = LVL_W'(full_scale(act_pn));
  assign tick_adv   = ref_tick && (div_cnt == act_div - 8'd1);
  assign period_end = tick_adv && (cnt == fs);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_cnt <= 8'd0;
      cnt     <= '0;
      pwm_q   <= 1'b0;
    end else begin
      if (ref_tick) div_cnt <= tick_adv ? 8'd0 : div_cnt + 8'd1;
      if (tick_adv) cnt <= period_end ? '0 : cnt + 1'b1;
      pwm_q <= en && (cnt < act_lvl);
    end
  end

  assign pwm_out = pwm_q;

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= fs); // R1
  AST_DIV_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    div_cnt < act_div); // R1
  AST_PERIOD_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    period_end |=> cnt == '0); // R1
  AST_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !pwm_q); // R9
  AST_ZERO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (act_lvl == '0) && !period_end |=> !pwm_q); // R12

endmodule

// File: rtl/bl_pwm_core.sv
module bl_pwm_core
  import bl_pwm_pkg::*;
#(
  parameter int PN_MAX    = 16,
  parameter bit LEVEL16   = 1'b1,
  parameter int DEFAULT_F = 4,
  parameter int RESET_PN  = 8,
  parameter int RESET_F   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data,
  output logic              pwm_out,
  output logic [LVL_W-1:0]  level_used
);

  bl_mode_e         mode;
  logic             fen;
  logic             en;
  logic [4:0]       pn_raw;
  logic [7:0]       f_raw;
  logic [LVL_W-1:0] level_raw;
  logic [4:0]       act_pn;
  logic [7:0]       act_div;
  logic [LVL_W-1:0] act_lvl;
  logic             period_end;

  bl_regs #(
    .LEVEL16 (LEVEL16),
    .RESET_PN(RESET_PN),
    .RESET_F (RESET_F)
  ) regs_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .addr     (addr),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .mode     (mode),
    .fen      (fen),
    .en       (en),
    .pn_raw   (pn_raw),
    .f_raw    (f_raw),
    .level_raw(level_raw)
  );

  bl_shadow #(
    .PN_MAX   (PN_MAX),
    .DEFAULT_F(DEFAULT_F),
    .RESET_PN (RESET_PN),
    .RESET_F  (RESET_F)
  ) shadow_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .period_end(period_end),
    .mode      (mode),
    .fen       (fen),
    .pn_raw    (pn_raw),
    .f_raw     (f_raw),
    .level_raw (level_raw),
    .act_pn    (act_pn),
    .act_div   (act_div),
    .act_lvl   (act_lvl)
  );

  bl_pwm_gen gen_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ref_tick  (ref_tick),
    .en        (en),
    .act_pn    (act_pn),
    .act_div   (act_div),
    .act_lvl   (act_lvl),
    .period_end(period_end),
    .pwm_out   (pwm_out)
  );

  assign level_used = act_lvl;

  AST_USED_MOVES_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    !period_end |=> $stable(level_used)); // R10

endmodule

// File: tb/bl_pwm_core_tb_top.sv
module bl_pwm_core_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_tick = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [7:0]  wr_data = 8'h00;
  logic [7:0]  rd_data, rd8;
  logic        pwm_out, pwm8;
  logic [15:0] level_used, lvl8;

  always #(CLK_PERIOD/2) clk = ~clk;

  bl_pwm_core dut_i (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .wr_en(wr_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
    .pwm_out(pwm_out), .level_used(level_used)
  );

  bl_pwm_core #(.LEVEL16(1'b0)) dut8_i (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .wr_en(wr_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd8),
    .pwm_out(pwm8), .level_used(lvl8)
  );

  int n_chk = 0;
  int n_err = 0;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // bench model of the programmed state
  int m_mode = 0, m_fen = 0, m_en = 0, m_pn = 8, m_f = 1, m_lvl = 0, m_hold = 0;
  int ref_step = 1;

  function automatic int b_div();
    if (m_fen == 0) return 4;
    return (m_f == 0) ? 1 : m_f;
  endfunction
  function automatic int b_pn();
    int p = m_pn & 31;
    return (p > 16) ? 16 : p;
  endfunction
  function automatic int b_lvl();
    int fs = (1 << b_pn()) - 1;
    if (m_mode != 2) return fs;
    return (m_lvl > fs) ? fs : m_lvl;
  endfunction

  // reference tick pattern: every cycle or every other cycle
  initial begin
    forever begin
      @(negedge clk);
      if (ref_step == 1) ref_tick = 1'b1;
      else ref_tick = ~ref_tick;
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    addr = 3'(a); wr_data = 8'(d); wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    case (a)
      0: begin m_mode = d & 3; m_fen = (d >> 2) & 1; end
      1: m_en = d & 1;
      2: m_hold = d & 255;
      3: m_lvl = (m_hold << 8) | (d & 255);
      4: m_pn = d & 31;
      5: m_f = d & 255;
      default: ;
    endcase
  endtask

  task automatic rd(input int a, output int d, output int d8);
    @(negedge clk);
    addr = 3'(a);
    #1;
    d = int'(rd_data);
    d8 = int'(rd8);
  endtask

  int o_div, o_pn, o_step;
  task automatic cfg_begin();
    o_div = b_div(); o_pn = b_pn(); o_step = ref_step;
  endtask
  task automatic cfg_settle();
    int md = (b_div() > o_div) ? b_div() : o_div;
    int mp = (b_pn() > o_pn) ? b_pn() : o_pn;
    int ms = (ref_step > o_step) ? ref_step : o_step;
    repeat (2 * (md << mp) * ms + 8) @(negedge clk);
  endtask

  // scoreboard
  typedef struct {
    string req;
    int    win;
    int    hi;
    int    rises;
  } exp_t;
  exp_t sb_q[$];
  int done_cnt = 0;

  initial begin
    forever begin
      exp_t it;
      int hi, rs, prev;
      wait (sb_q.size() > 0);
      it = sb_q.pop_front();
      @(negedge clk);
      prev = int'(pwm_out); hi = 0; rs = 0;
      for (int i = 0; i < it.win; i++) begin
        @(negedge clk);
        if (pwm_out) hi++;
        if (pwm_out && prev == 0) rs++;
        prev = int'(pwm_out);
      end
      chk(it.req, "high cycles over two periods", hi, it.hi);
      chk(it.req, "rising edges over two periods", rs, it.rises);
      done_cnt++;
    end
  end

  task automatic measure(input string req);
    exp_t it;
    int per = (b_div() << b_pn()) * ref_step;
    int h = (m_en != 0) ? b_lvl() * b_div() * ref_step : 0;
    int target = done_cnt + 1;
    it.req = req;
    it.win = 2 * per;
    it.hi = 2 * h;
    it.rises = (h > 0 && h < per) ? 2 : 0;
    sb_q.push_back(it);
    wait (done_cnt == target);
    chk(req, "level_used", level_used, b_lvl());
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    n_err++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    int d, d8, prev;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R3: reset state
    chk("R3", "pwm_out", pwm_out, 0);
    chk("R3", "level_used", level_used, 0);
    rd(0, d, d8); chk("R3", "mode reg", d, 0);
    rd(1, d, d8); chk("R3", "ctrl reg", d, 0);
    rd(4, d, d8); chk("R3", "bit count", d, 8);
    rd(5, d, d8); chk("R3", "pre-divider", d, 1);
    rd(3, d, d8); chk("R3", "level low", d, 0);

    // R1 R5 R2: register mode, programmed divider
    cfg_begin();
    wr(0, 6); wr(1, 1); wr(4, 4); wr(5, 1); wr(2, 0); wr(3, 5);
    rd(0, d, d8); chk("R2", "mode readback", d, 6);
    rd(3, d, d8); chk("R2", "level low readback", d, 5);
    cfg_settle();
    measure("R1");

    cfg_begin();
    wr(4, 3); wr(5, 3); wr(3, 2);
    cfg_settle();
    measure("R1");

    // R4: default divider when frequency-set enable is clear
    cfg_begin();
    wr(0, 2);
    cfg_settle();
    measure("R4");

    // R4: zero pre-divider acts as one
    cfg_begin();
    wr(0, 6); wr(5, 0);
    cfg_settle();
    measure("R4");

    // R6: stored level above full scale
    cfg_begin();
    wr(5, 2); wr(3, 200);
    cfg_settle();
    measure("R6");
    chk("R6", "level_used clamp", level_used, 7);

    // R5: non-register modes use full scale
    cfg_begin();
    wr(3, 2); wr(0, 4);
    cfg_settle();
    measure("R5");
    cfg_begin(); wr(0, 5); cfg_settle();
    chk("R5", "preset mode level", level_used, 7);
    cfg_begin(); wr(0, 7); cfg_settle();
    chk("R5", "product mode level", level_used, 7);

    // R12: zero level
    cfg_begin();
    wr(0, 6); wr(3, 0);
    cfg_settle();
    measure("R12");

    // R9: enable clear holds output low, level unaffected
    cfg_begin();
    wr(3, 3); wr(1, 0);
    cfg_settle();
    measure("R9");
    chk("R9", "level_used while disabled", level_used, 3);
    wr(1, 1);
    repeat (4) @(negedge clk);
    measure("R9");

    // R1: gaps in the reference tick stretch the waveform
    cfg_begin();
    ref_step = 2;
    wr(5, 1);
    cfg_settle();
    measure("R1");
    cfg_begin();
    ref_step = 1;
    cfg_settle();

    // R2: upper bits of bit count dropped
    cfg_begin();
    wr(4, 8'hE2); wr(0, 4);
    rd(4, d, d8); chk("R2", "bit count masked", d, 2);
    cfg_settle();
    chk("R2", "full scale after masked count", level_used, 3);

    // R7 R8: 16-bit assembly and 8-bit variant
    cfg_begin();
    wr(0, 6); wr(4, 10); wr(3, 0);
    wr(2, 1);
    rd(2, d, d8); chk("R7", "high byte readback before low write", d, 0);
    rd(3, d, d8); chk("R8", "narrow build low byte reads zero", d8, 0);
    chk("R8", "narrow build high byte readback", d8, 0);
    wr(3, 8'h23);
    rd(2, d, d8); chk("R7", "high byte readback", d, 1);
    chk("R8", "narrow build high byte readback", d8, 1);
    rd(3, d, d8); chk("R7", "low byte readback", d, 8'h23);
    cfg_settle();
    measure("R7");
    chk("R7", "assembled level", level_used, 16'h0123);
    chk("R8", "narrow build level", lvl8, 1);

    // R10: change applied only at period end
    cfg_begin();
    wr(4, 4); wr(2, 0); wr(3, 5);
    cfg_settle();
    prev = int'(pwm_out);
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      if (prev == 1 && pwm_out == 1'b0) break;
      prev = int'(pwm_out);
    end
    wr(3, 9);
    chk("R10", "level_used just after write", level_used, 5);
    repeat (20) @(negedge clk);
    chk("R10", "level_used after period end", level_used, 9);

    // R11: bit count above the limit
    wr(0, 4);
    repeat (40) @(negedge clk);
    wr(4, 20);
    repeat (40) @(negedge clk);
    chk("R11", "clamped full scale", level_used, 16'hFFFF);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule